// File: doc/BRIEF.md
# Banked Bit-Addressable Scratchpad

This block is the 256-byte internal data space of a small 8-bit controller core. The lower half is one byte array that the core sees in three ways. The bottom 32 bytes form four banks of eight working registers. Bytes 20h to 2Fh also answer to 128 single-bit addresses. Bytes 30h to 7Fh are plain storage. The upper half is a sparse window. It holds the stack pointer and a configurable set of bit-addressable special registers. Every other upper address reads as zero.

The core reaches the storage through four paths that all resolve to the same bytes. The first is a byte port that takes a direct address, or a register number that is steered through the active bank. The second is a single-bit port that reads, sets or clears one bit. The third is a push/pop port driven by an 8-bit stack pointer. The fourth is a two-bit bank-select input. All reads are combinational. All updates take effect at the rising clock edge, so a value written in one cycle is visible in the next.

Top module: `scratch_space`

## Requirements
- R1: After reset every lower-half byte and every special register reads 00h, every bit reads 0, and the stack pointer reads 07h.
- R2: With `byte_rel`=1 the byte port addresses byte (bank_sel×8)+byte_addr[2:0]. Bits 7:3 of `byte_addr` are ignored in this mode.
- R3: With `byte_rel`=0 the byte port addresses `byte_addr` directly. `byte_rdata` shows the addressed byte combinationally, and a write with `byte_we`=1 is visible from the next cycle.
- R4: `bit_op` encodings are 00 read only, 01 set, 10 clear, and 11 read only. A bit number k below 80h lives in byte 20h+(k>>3) at position k&7, and `bit_rdata` returns that bit.
- R5: A bit number k of 80h or above lives in byte (k & F8h) at position k&7.
- R6: A set or clear changes only the addressed bit of its byte, and the new byte is readable in the next cycle.
- R7: The stack pointer is the byte at 81h. It resets to 07h, can be read and loaded through the byte port, and is shown on `stack_ptr`. It is not bit-addressable, because bit numbers 80h–87h select byte 80h.
- R8: A push increments the stack pointer and then stores `push_data` at the new value, so the first push after reset lands at 08h.
- R9: `pop_data` shows the byte at the current stack pointer. A pop decrements the pointer at the edge.
- R10: The stack pointer wraps modulo 256 in both directions, and no fault is raised.
- R11: The special registers sit at 80h + 16×i for i below NUM_SPECIAL (80h, 90h, A0h and B0h by default). Any other upper address except 81h reads 00h, and writes to it (byte or bit) are ignored.
- R12: When several operations fall in one cycle, only the highest-priority one takes effect. The order is push, then pop, then byte write, then bit set or clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Active register bank |
| byte_we | input | 1 | Byte write strobe |
| byte_rel | input | 1 | 1: register-relative address, 0: direct |
| byte_addr | input | 8 | Byte address or register number |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Addressed byte (combinational) |
| bit_op | input | 2 | Bit operation: 00/11 read, 01 set, 10 clear |
| bit_addr | input | 8 | Bit number |
| bit_rdata | output | 1 | Addressed bit (combinational) |
| push_en | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| pop_en | input | 1 | Pop request |
| pop_data | output | 8 | Byte at top of stack |
| stack_ptr | output | 8 | Current stack pointer |

## Verification
On every cycle the assertions check the stack pointer's arithmetic. They cover increment on push, decrement on pop, wrap-around, and holding when nothing touches it. They also check that a lower-half write lands at its address, that undefined upper addresses read zero, and that writes to those addresses leave the special registers untouched. What only the directed scenarios can show is the address mapping itself. That covers bank steering, the bit-to-byte mapping in both regions, read-modify-write that keeps the neighbouring bits, and the arbitration order when operations collide in one cycle.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
   localparam int BYTE_W     = 8;
   localparam int BANK_W     = 2;
   localparam int REGNUM_W   = 3;
   localparam int LOWER_SIZE = 128;
   localparam int LOWER_AW   = $clog2(LOWER_SIZE);

   typedef logic [BYTE_W-1:0] byte_t;

   localparam byte_t BIT_REGION = 8'h20;
   localparam byte_t SP_ADDR    = 8'h81;
   localparam byte_t SPC_BASE   = 8'h80;

   typedef enum logic [1:0] {
      BOP_READ = 2'b00,
      BOP_SET  = 2'b01,
      BOP_CLR  = 2'b10,
      BOP_HOLD = 2'b11
   } bit_op_e;

   function automatic byte_t bank_reg_addr(input logic [BANK_W-1:0] bank,
                                           input logic [REGNUM_W-1:0] regno);
      return byte_t'({bank, regno});
   endfunction

   function automatic byte_t bit_home_byte(input byte_t bnum);
      if (bnum[7])
         return {bnum[7:3], 3'b000};
      return BIT_REGION + byte_t'(bnum[6:3]);
   endfunction
endpackage

// File: rtl/scratch_sp.sv
module scratch_sp
   import scratch_pkg::*;
#(
   parameter byte_t SP_RESET = 8'h07
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  inc,
   input  logic  dec,
   input  logic  load,
   input  byte_t load_val,
   output byte_t sp
);
   byte_t sp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sp_q <= SP_RESET;
      else if (inc)   sp_q <= sp_q + 8'd1;
      else if (dec)   sp_q <= sp_q - 8'd1;
      else if (load)  sp_q <= load_val;
   end

   assign sp = sp_q;

   // R8
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> sp_q == $past(sp_q) + 8'd1);

   // R9
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |=> sp_q == $past(sp_q) - 8'd1);

   // R7
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec && !load) |=> $stable(sp_q));
endmodule

// File: rtl/scratch_store.sv
module scratch_store
   import scratch_pkg::*;
#(
   parameter int NUM_SPECIAL    = 4,
   parameter int SPECIAL_STRIDE = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  byte_t wr_addr,
   input  byte_t wr_data,
   input  byte_t rd_a_addr,
   input  byte_t rd_b_addr,
   input  byte_t rd_c_addr,
   output byte_t rd_a,
   output byte_t rd_b,
   output byte_t rd_c
);
   localparam int SPC_SPAN = NUM_SPECIAL * SPECIAL_STRIDE;

   generate
      if (NUM_SPECIAL < 1 || SPC_SPAN > LOWER_SIZE || (SPECIAL_STRIDE % 8) != 0)
      begin : g_bad_cfg
         $error("scratch_store: special-register layout does not fit the upper window");
      end
   endgenerate

   byte_t lower_q [LOWER_SIZE];
   logic [NUM_SPECIAL-1:0][BYTE_W-1:0] spc_q;

   // per-register address constants
   byte_t spc_addr [NUM_SPECIAL];
   genvar gi;
   generate
      for (gi = 0; gi < NUM_SPECIAL; gi++) begin : g_spc
         assign spc_addr[gi] = SPC_BASE + byte_t'(gi * SPECIAL_STRIDE);
      end
   endgenerate

   function automatic byte_t fetch(input byte_t a);
      byte_t v;
      v = '0;
      if (!a[7]) begin
         v = lower_q[a[LOWER_AW-1:0]];
      end else begin
         for (int i = 0; i < NUM_SPECIAL; i++)
            if (a == spc_addr[i]) v = spc_q[i];
      end
      return v;
   endfunction

   function automatic logic is_special(input byte_t a);
      logic h;
      h = 1'b0;
      for (int i = 0; i < NUM_SPECIAL; i++)
         if (a == spc_addr[i]) h = 1'b1;
      return h;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LOWER_SIZE; i++) lower_q[i] <= '0;
         spc_q <= '0;
      end else if (wr_en) begin
         if (!wr_addr[7]) lower_q[wr_addr[LOWER_AW-1:0]] <= wr_data;
         for (int i = 0; i < NUM_SPECIAL; i++)
            if (wr_addr == spc_addr[i]) spc_q[i] <= wr_data;
      end
   end

   assign rd_a = fetch(rd_a_addr);
   assign rd_b = fetch(rd_b_addr);
   assign rd_c = fetch(rd_c_addr);

   // R3
   lower_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[7]) |=> lower_q[$past(wr_addr[LOWER_AW-1:0])] == $past(wr_data));

   // R11
   undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[7] && !is_special(wr_addr)) |=> $stable(spc_q));

   // R11
   undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_addr[7] && !is_special(rd_a_addr)) |-> rd_a == 8'h00);
endmodule

// File: rtl/scratch_space.sv
module scratch_space
   import scratch_pkg::*;
#(
   parameter int    NUM_SPECIAL    = 4,
   parameter int    SPECIAL_STRIDE = 16,
   parameter byte_t SP_RESET       = 8'h07
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  bank_sel,
   input  logic        byte_we,
   input  logic        byte_rel,
   input  logic [7:0]  byte_addr,
   input  logic [7:0]  byte_wdata,
   output logic [7:0]  byte_rdata,
   input  logic [1:0]  bit_op,
   input  logic [7:0]  bit_addr,
   output logic        bit_rdata,
   input  logic        push_en,
   input  logic [7:0]  push_data,
   input  logic        pop_en,
   output logic [7:0]  pop_data,
   output logic [7:0]  stack_ptr
);
   byte_t   byte_phys, bit_byte, sp, rd_a, rd_b, rd_c;
   byte_t   wr_addr, wr_data, bit_new;
   logic    wr_en, sp_load;
   bit_op_e bop;

   assign bop       = bit_op_e'(bit_op);
   assign byte_phys = byte_rel ? bank_reg_addr(bank_sel, byte_addr[REGNUM_W-1:0])
                               : byte_addr;
   assign bit_byte  = bit_home_byte(bit_addr);

   always_comb begin
      bit_new = rd_b;
      bit_new[bit_addr[2:0]] = (bop == BOP_SET);
   end

   // arbitration: push > pop > byte write > bit write
   always_comb begin
      wr_en   = 1'b0;
      wr_addr = byte_phys;
      wr_data = byte_wdata;
      if (push_en) begin
         wr_en   = 1'b1;
         wr_addr = sp + 8'd1;
         wr_data = push_data;
      end else if (pop_en) begin
         wr_en   = 1'b0;
      end else if (byte_we) begin
         wr_en   = 1'b1;
      end else if (bop == BOP_SET || bop == BOP_CLR) begin
         wr_en   = 1'b1;
         wr_addr = bit_byte;
         wr_data = bit_new;
      end
   end

   assign sp_load = !push_en && !pop_en && byte_we && (byte_phys == SP_ADDR);

   scratch_sp #(.SP_RESET(SP_RESET)) i_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (push_en),
      .dec      (pop_en && !push_en),
      .load     (sp_load),
      .load_val (byte_wdata),
      .sp       (sp)
   );

   scratch_store #(
      .NUM_SPECIAL    (NUM_SPECIAL),
      .SPECIAL_STRIDE (SPECIAL_STRIDE)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_a_addr (byte_phys),
      .rd_b_addr (bit_byte),
      .rd_c_addr (sp),
      .rd_a      (rd_a),
      .rd_b      (rd_b),
      .rd_c      (rd_c)
   );

   assign byte_rdata = (byte_phys == SP_ADDR) ? sp : rd_a;
   assign bit_rdata  = rd_b[bit_addr[2:0]];
   assign pop_data   = (sp == SP_ADDR) ? sp : rd_c;
   assign stack_ptr  = sp;

   // R12
   push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en && byte_we && byte_phys == SP_ADDR) |=> stack_ptr == $past(sp) + 8'd1);
endmodule

// File: tb/test_scratch_space.sv
`timescale 1ns/1ps
module test_scratch_space;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] bank_sel;
   logic       byte_we, byte_rel;
   logic [7:0] byte_addr, byte_wdata, byte_rdata;
   logic [1:0] bit_op;
   logic [7:0] bit_addr;
   logic       bit_rdata;
   logic       push_en, pop_en;
   logic [7:0] push_data, pop_data, stack_ptr;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   scratch_space i_scratch_space (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
      .byte_we(byte_we), .byte_rel(byte_rel), .byte_addr(byte_addr),
      .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
      .bit_op(bit_op), .bit_addr(bit_addr), .bit_rdata(bit_rdata),
      .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
      .pop_data(pop_data), .stack_ptr(stack_ptr)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic idle();
      byte_we = 0; byte_rel = 0; bit_op = 2'b00; push_en = 0; pop_en = 0;
   endtask

   // apply the driven operation at the next edge, return at the following negedge
   task automatic step();
      @(posedge clk); @(negedge clk);
      idle();
      #1;
   endtask

   task automatic wr_byte(input logic rel, input logic [7:0] a, input logic [7:0] d);
      byte_rel = rel; byte_addr = a; byte_wdata = d; byte_we = 1; step();
   endtask

   task automatic rd_byte(input logic rel, input logic [7:0] a, output logic [7:0] d);
      byte_rel = rel; byte_addr = a; #1; d = byte_rdata;
   endtask

   task automatic bit_do(input logic [1:0] op, input logic [7:0] b);
      bit_addr = b; bit_op = op; step();
   endtask

   task automatic rd_bit(input logic [7:0] b, output logic v);
      bit_addr = b; bit_op = 2'b00; #1; v = bit_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d; logic v;
      rd_byte(0, 8'h00, d); chk("R1 byte 00h", d, 8'h00);
      rd_byte(0, 8'h2F, d); chk("R1 byte 2Fh", d, 8'h00);
      rd_byte(0, 8'hB0, d); chk("R1 special B0h", d, 8'h00);
      rd_bit(8'h05, v);     chk("R1 bit 05h", {7'b0, v}, 8'h00);
      chk("R1 stack_ptr", stack_ptr, 8'h07);
      rd_byte(0, 8'h81, d); chk("R7 SP via byte port", d, 8'h07);
   endtask

   task automatic t_direct();
      logic [7:0] d;
      wr_byte(0, 8'h30, 8'hA5);
      wr_byte(0, 8'h7F, 8'h3C);
      rd_byte(0, 8'h30, d); chk("R3 byte 30h", d, 8'hA5);
      rd_byte(0, 8'h7F, d); chk("R3 byte 7Fh", d, 8'h3C);
   endtask

   task automatic t_banks();
      logic [7:0] d;
      for (int b = 0; b < 4; b++) begin
         bank_sel = 2'(b);
         wr_byte(1, 8'(b + 1), 8'(8'h40 + b));
      end
      for (int b = 0; b < 4; b++) begin
         rd_byte(0, 8'(b * 8 + b + 1), d);
         chk("R2 bank register lands at bank*8+n", d, 8'(8'h40 + b));
      end
      bank_sel = 2'd2;
      rd_byte(1, 8'hFB, d); chk("R2 upper bits ignored (R3 of bank 2)", d, 8'h42);
      bank_sel = 2'd0;
   endtask

   task automatic t_bits();
      logic [7:0] d; logic v;
      bit_do(2'b01, 8'h00);
      rd_byte(0, 8'h20, d); chk("R4 bit 00h -> 20h.0", d, 8'h01);
      bit_do(2'b01, 8'h7F);
      rd_byte(0, 8'h2F, d); chk("R4 bit 7Fh -> 2Fh.7", d, 8'h80);
      rd_bit(8'h7F, v);     chk("R4 bit read", {7'b0, v}, 8'h01);
      wr_byte(0, 8'h25, 8'hFF);
      bit_do(2'b10, 8'h2B);
      rd_byte(0, 8'h25, d); chk("R6 clear keeps neighbours", d, 8'hF7);
      bit_do(2'b11, 8'h2B);
      rd_byte(0, 8'h25, d); chk("R4 op 11 changes nothing", d, 8'hF7);
      bit_do(2'b01, 8'h2B);
      rd_byte(0, 8'h25, d); chk("R6 set restores byte", d, 8'hFF);
   endtask

   task automatic t_special();
      logic [7:0] d; logic v;
      bit_do(2'b01, 8'h87);
      rd_byte(0, 8'h80, d); chk("R5 bit 87h -> 80h.7", d, 8'h80);
      bit_do(2'b01, 8'h93);
      rd_byte(0, 8'h90, d); chk("R5 bit 93h -> 90h.3", d, 8'h08);
      rd_byte(0, 8'h81, d); chk("R7 SP untouched by bit 8xh", d, 8'h07);
      bit_do(2'b01, 8'h8A);
      rd_bit(8'h8A, v); chk("R11 bit in undefined 88h", {7'b0, v}, 8'h00);
      rd_byte(0, 8'h88, d); chk("R11 undefined 88h after set", d, 8'h00);
      wr_byte(0, 8'h85, 8'h5A);
      rd_byte(0, 8'h85, d); chk("R11 undefined 85h write ignored", d, 8'h00);
      wr_byte(0, 8'hA0, 8'h33);
      rd_byte(0, 8'hA0, d); chk("R11 defined A0h", d, 8'h33);
   endtask

   task automatic t_stack();
      logic [7:0] d;
      push_data = 8'h11; push_en = 1; step();
      push_data = 8'h22; push_en = 1; step();
      chk("R8 sp after two pushes", stack_ptr, 8'h09);
      rd_byte(0, 8'h08, d); chk("R8 first push at 08h", d, 8'h11);
      chk("R9 pop_data top", pop_data, 8'h22);
      pop_en = 1; step();
      chk("R9 sp after pop", stack_ptr, 8'h08);
      chk("R9 pop_data next", pop_data, 8'h11);
      wr_byte(0, 8'h81, 8'hFF);
      chk("R7 SP loaded via byte port", stack_ptr, 8'hFF);
      push_data = 8'h77; push_en = 1; step();
      chk("R10 wrap up", stack_ptr, 8'h00);
      rd_byte(0, 8'h00, d); chk("R10 push after wrap at 00h", d, 8'h77);
      pop_en = 1; step();
      chk("R10 wrap down", stack_ptr, 8'hFF);
      wr_byte(0, 8'h81, 8'h07);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      push_data = 8'h99; push_en = 1;
      byte_addr = 8'h40; byte_wdata = 8'hEE; byte_we = 1; step();
      rd_byte(0, 8'h40, d); chk("R12 push beats byte write", d, 8'h00);
      rd_byte(0, 8'h08, d); chk("R12 push stored", d, 8'h99);
      pop_en = 1; byte_addr = 8'h41; byte_wdata = 8'h55; byte_we = 1; step();
      rd_byte(0, 8'h41, d); chk("R12 pop beats byte write", d, 8'h00);
      chk("R12 pop took effect", stack_ptr, 8'h07);
      byte_addr = 8'h26; byte_wdata = 8'h10; byte_we = 1;
      bit_addr = 8'h30; bit_op = 2'b01; step();
      rd_byte(0, 8'h26, d); chk("R12 byte write beats bit set", d, 8'h10);
   endtask

   initial begin
      idle();
      bank_sel = 0; byte_addr = 0; byte_wdata = 0; bit_addr = 0; push_data = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #1;
      t_reset();
      t_direct();
      t_banks();
      t_bits();
      t_special();
      t_stack();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule